// File: doc/BRIEF.md
# Streaming PSA Signature Checker

This block predicts the 16-bit pseudo-signature that a debug target produces after a run of memory words has been clocked through its signature register. It then compares that prediction with the signature the target reported. A host controller pulses `start` with the low bits of the start address, a word count and a mode. In data mode the block takes the expected memory words one per handshake on a valid/ready stream. In erase-check mode it needs no stream. It folds the all-ones word in once per clock, count times. When all words have been folded in, the block waits for the reported signature on its own valid strobe. It then raises exactly one of `pass` or `fail` and holds that result until the next accepted start.

The register starts from the start address minus two, kept to 16 bits. Each word step works as follows:

- If bit 15 is set, the register is XORed with the polynomial 0x0805, shifted left by one, and bit 0 is forced to 1.
- If bit 15 is clear, the register is only shifted left by one.
- In both cases the incoming word is XORed in after the shift.

A count of zero makes the seed itself the expected signature.

The controller is a four-state machine:

- `ST_IDLE`: after reset. An accepted start moves it to `ST_RUN`, or straight to `ST_WAIT_SIG` when the count is zero.
- `ST_RUN`: folds in words. On the last word it moves to `ST_WAIT_SIG`.
- `ST_WAIT_SIG`: on `sig_valid` it moves to `ST_DONE`.
- `ST_DONE`: holds the result. A new start leaves it the same way as from `ST_IDLE`.

Top module: `psa_sig_checker`

## Requirements
- R1: On an accepted start the signature register loads `start_addr - 2` modulo 2^16. With `word_count` = 0 that seed is the value the reported signature is compared with.
- R2: For a word step with register bit 15 = 1, the register becomes ((reg XOR 0x0805) << 1) with bit 0 set to 1, before the word is XORed in.
- R3: For a word step with register bit 15 = 0, the register becomes (reg << 1) with bit 0 = 0, before the word is XORed in.
- R4: In data mode (`erase_mode` = 0 at start), the word on `in_data` is XORed in after the shift, and one word is consumed on each clock where `in_valid` and `in_ready` are both 1. `in_ready` is 1 only while words remain.
- R5: In erase-check mode (`erase_mode` = 1 at start), 0xFFFF is XORed in, one word per clock, with `in_ready` held at 0. `in_valid` and `in_data` have no effect.
- R6: `pass` = 1 only when the 16-bit `sig_value` taken equals the final register exactly. Otherwise `fail` = 1. The two are never 1 together.
- R7: `pass`, `fail` and `done` hold until the next accepted start. A start pulse while `busy` = 1 is ignored.
- R8: After reset `busy`, `done`, `pass`, `fail` and `in_ready` are 0.
- R9: `sig_valid` is ignored unless all words have been folded in and no result is yet held.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a new signature check (accepted when not busy) |
| erase_mode | input | 1 | 1 = erase-check mode, 0 = data mode; sampled at start |
| start_addr | input | SIG_W | Low bits of the start address |
| word_count | input | CNT_W | Number of words to fold in |
| in_valid | input | 1 | Data word valid (data mode) |
| in_data | input | SIG_W | Expected memory word |
| in_ready | output | 1 | Block takes a word this cycle if valid |
| sig_valid | input | 1 | Reported signature valid |
| sig_value | input | SIG_W | Signature reported by the target |
| busy | output | 1 | Folding words or waiting for the signature |
| done | output | 1 | A result is held |
| pass | output | 1 | Reported signature matched |
| fail | output | 1 | Reported signature differed |

## Verification
The bench builds the block with `CNT_W` = 10, so the full-range count of 1023 can be run in erase-check mode and the counter's largest load is exercised. `SIG_W` stays at 16 with polynomial 0x0805. Hand-derived values pin down both feedback branches:

- Seed 0x3100 with one erase word gives 0x9DFF.
- Seed 0x8000 with a zero data word gives 0x100B.
- Start address 0x0001 wraps the seed to 0xFFFF.

The stream is driven with valid gaps. Early and late signature strobes test when a strobe is taken, and a start pulse mid-run tests that a busy block ignores it.

// File: rtl/psa_pkg.sv
package psa_pkg;

    localparam int unsigned SIG_W_DEF = 16;
    localparam int unsigned CNT_W_DEF = 16;
    localparam logic [15:0] POLY_DEF  = 16'h0805;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_RUN      = 2'd1,
        ST_WAIT_SIG = 2'd2,
        ST_DONE     = 2'd3
    } psa_state_e;

endpackage

// File: rtl/psa_step.sv
module psa_step #(
    parameter int unsigned SIG_W = 16,
    parameter logic [SIG_W-1:0] POLY = 16'h0805
) (
    input  logic [SIG_W-1:0] cur,
    input  logic [SIG_W-1:0] word,
    output logic [SIG_W-1:0] nxt
);
    logic             fb;
    logic [SIG_W-1:0] shifted;

    assign fb = cur[SIG_W-1];

    // bit 0 receives the feedback as a forced one; upper bits take the
    // shifted register, optionally folded with the polynomial (R2, R3)
    assign shifted[0] = fb;
    for (genvar i = 1; i < SIG_W; i++) begin : g_bit
        assign shifted[i] = cur[i-1] ^ (fb & POLY[i-1]);
    end

    assign nxt = shifted ^ word;
endmodule

// File: rtl/psa_len_ctr.sv
module psa_len_ctr #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             dec,
    output logic             at_one
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (dec) begin
            cnt_q <= cnt_q - ONE;
        end
    end

    assign at_one = (cnt_q == ONE);

    p_no_underflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (dec && !load) |-> (cnt_q != '0));
endmodule

// File: rtl/psa_ctrl.sv
module psa_ctrl
    import psa_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       erase_mode,
    input  logic       count_zero,
    input  logic       last_word,
    input  logic       in_valid,
    input  logic       sig_valid,
    output psa_state_e state,
    output logic       erase_q,
    output logic       accept_start,
    output logic       step_en,
    output logic       sig_take,
    output logic       in_ready,
    output logic       busy,
    output logic       done
);
    psa_state_e state_q, state_d;
    logic       erase_r;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            erase_r <= 1'b0;
        end else begin
            state_q <= state_d;
            if (accept_start) begin
                erase_r <= erase_mode;
            end
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE, ST_DONE: begin
                if (start) begin
                    state_d = count_zero ? ST_WAIT_SIG : ST_RUN;
                end
            end
            ST_RUN: begin
                if (step_en && last_word) begin
                    state_d = ST_WAIT_SIG;
                end
            end
            ST_WAIT_SIG: begin
                if (sig_valid) begin
                    state_d = ST_DONE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        accept_start = 1'b0;
        step_en      = 1'b0;
        sig_take     = 1'b0;
        in_ready     = 1'b0;
        busy         = 1'b0;
        done         = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                accept_start = start;
            end
            ST_RUN: begin
                busy     = 1'b1;
                in_ready = !erase_r;
                step_en  = erase_r || in_valid;
            end
            ST_WAIT_SIG: begin
                busy     = 1'b1;
                sig_take = sig_valid;
            end
            ST_DONE: begin
                done         = 1'b1;
                accept_start = start;
            end
            default: ;
        endcase
    end

    assign state   = state_q;
    assign erase_q = erase_r;

    p_ready_data_run_r5: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> (state_q == ST_RUN && !erase_r));
    p_busy_start_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && state_q == ST_RUN && !(step_en && last_word)) |=> (state_q == ST_RUN));
    p_sig_only_waiting_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (sig_valid && state_q == ST_RUN) |=> (state_q != ST_DONE));
endmodule

// File: rtl/psa_sig_checker.sv
module psa_sig_checker
    import psa_pkg::*;
#(
    parameter int unsigned SIG_W = 16,
    parameter int unsigned CNT_W = 16,
    parameter logic [SIG_W-1:0] POLY = 16'h0805
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             erase_mode,
    input  logic [SIG_W-1:0] start_addr,
    input  logic [CNT_W-1:0] word_count,
    input  logic             in_valid,
    input  logic [SIG_W-1:0] in_data,
    output logic             in_ready,
    input  logic             sig_valid,
    input  logic [SIG_W-1:0] sig_value,
    output logic             busy,
    output logic             done,
    output logic             pass,
    output logic             fail
);
    localparam logic [SIG_W-1:0] SEED_OFS  = SIG_W'(2);
    localparam logic [SIG_W-1:0] ERASE_PAT = '1;

    psa_state_e       state;
    logic             erase_q, accept_start, step_en, sig_take, last_word;
    logic [SIG_W-1:0] sig_q, sig_nxt, fold_word;
    logic             pass_q, fail_q;

    psa_ctrl u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (start),
        .erase_mode   (erase_mode),
        .count_zero   (word_count == '0),
        .last_word    (last_word),
        .in_valid     (in_valid),
        .sig_valid    (sig_valid),
        .state        (state),
        .erase_q      (erase_q),
        .accept_start (accept_start),
        .step_en      (step_en),
        .sig_take     (sig_take),
        .in_ready     (in_ready),
        .busy         (busy),
        .done         (done)
    );

    psa_len_ctr #(.CNT_W(CNT_W)) u_len (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept_start),
        .load_val (word_count),
        .dec      (step_en),
        .at_one   (last_word)
    );

    assign fold_word = erase_q ? ERASE_PAT : in_data;

    psa_step #(.SIG_W(SIG_W), .POLY(POLY)) u_step (
        .cur  (sig_q),
        .word (fold_word),
        .nxt  (sig_nxt)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sig_q <= '0;
        end else if (accept_start) begin
            sig_q <= start_addr - SEED_OFS;
        end else if (step_en) begin
            sig_q <= sig_nxt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pass_q <= 1'b0;
            fail_q <= 1'b0;
        end else if (accept_start) begin
            pass_q <= 1'b0;
            fail_q <= 1'b0;
        end else if (sig_take) begin
            pass_q <= (sig_value == sig_q);
            fail_q <= (sig_value != sig_q);
        end
    end

    assign pass = pass_q;
    assign fail = fail_q;

    p_seed_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
        accept_start |=> (sig_q == $past(start_addr) - SEED_OFS));
    p_pass_fail_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(pass && fail));
    p_result_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> ($stable(pass) && $stable(fail) && done));
    p_done_has_result_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (pass || fail));
    p_reg_frozen_wait_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT_SIG && !start) |=> $stable(sig_q));
endmodule

// File: tb/test_psa_sig_checker.sv
module test_psa_sig_checker;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int SW = 16;
    localparam int CW = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          erase_mode = 1'b0;
    logic [SW-1:0] start_addr = '0;
    logic [CW-1:0] word_count = '0;
    logic          in_valid = 1'b0;
    logic [SW-1:0] in_data = '0;
    logic          in_ready;
    logic          sig_valid = 1'b0;
    logic [SW-1:0] sig_value = '0;
    logic          busy, done, pass, fail;

    int total = 0;
    int fails = 0;

    psa_sig_checker #(.SIG_W(SW), .CNT_W(CW), .POLY(16'h0805)) i_psa_sig_checker (
        .clk(clk), .rst_n(rst_n), .start(start), .erase_mode(erase_mode),
        .start_addr(start_addr), .word_count(word_count), .in_valid(in_valid),
        .in_data(in_data), .in_ready(in_ready), .sig_valid(sig_valid),
        .sig_value(sig_value), .busy(busy), .done(done), .pass(pass), .fail(fail)
    );

    always #10 clk = ~clk;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic int unsigned ref_step(input int unsigned s, input int unsigned w);
        int unsigned r;
        if ((s & 32'h8000) != 0) r = ((s ^ 32'h0805) << 1) | 32'h1;
        else                     r = s << 1;
        return (r ^ w) & 32'hFFFF;
    endfunction

    logic [SW-1:0] wq [$];

    function automatic logic [SW-1:0] ref_sig(input bit er, input logic [SW-1:0] a, input int n);
        int unsigned s = (int'(a) + 32'h10000 - 2) & 32'hFFFF;
        for (int k = 0; k < n; k++) s = ref_step(s, er ? 32'hFFFF : int'(wq[k]));
        return s[SW-1:0];
    endfunction

    // behavioural cycle model: 0 idle, 1 folding, 2 waiting, 3 holding
    int          m_state = 0;
    int          m_left = 0;
    bit          m_erase = 0;
    int unsigned m_sig = 0;
    bit          m_pass = 0, m_fail = 0;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_state = 0; m_left = 0; m_erase = 0; m_sig = 0; m_pass = 0; m_fail = 0;
        end else begin
            case (m_state)
                0, 3: if (start) begin
                    m_sig   = (int'(start_addr) + 32'h10000 - 2) & 32'hFFFF;
                    m_left  = int'(word_count);
                    m_erase = erase_mode;
                    m_pass  = 0; m_fail = 0;
                    m_state = (m_left == 0) ? 2 : 1;
                end
                1: if (m_erase || in_valid) begin
                    m_sig = ref_step(m_sig, m_erase ? 32'hFFFF : int'(in_data));
                    m_left--;
                    if (m_left == 0) m_state = 2;
                end
                2: if (sig_valid) begin
                    m_pass  = (int'(sig_value) == m_sig);
                    m_fail  = !m_pass;
                    m_state = 3;
                end
                default: m_state = 0;
            endcase
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            chk(busy == (m_state == 1 || m_state == 2), "R7 busy cycle", busy, (m_state == 1 || m_state == 2));
            chk(done == (m_state == 3), "R7 done cycle", done, (m_state == 3));
            chk(pass == m_pass && fail == m_fail, "R6 result cycle", {pass, fail}, {m_pass, m_fail});
            chk(in_ready == (m_state == 1 && !m_erase), "R4 R5 ready cycle", in_ready, (m_state == 1 && !m_erase));
        end
    end

    task automatic run_op(input bit er, input logic [SW-1:0] a, input int n, input bit gaps,
                          input bit early, input bit mid, input logic [SW-1:0] rep,
                          input bit exp_pass, input string tag);
        int idx = 0;
        int cyc = 0;
        bit rdy;
        @(posedge clk); #3;
        start = 1; erase_mode = er; start_addr = a; word_count = CW'(n);
        @(posedge clk); #3;
        start = 0;
        while (!done && cyc < 5000) begin
            start = (mid && cyc == 3);
            if (start) begin start_addr = a ^ 16'h5555; erase_mode = !er; end
            if (!er) begin
                in_valid = (idx < n) && (!gaps || (cyc % 3 != 1));
                in_data  = (idx < n) ? wq[idx] : 16'hDEAD;
            end else begin
                in_valid = cyc[0];
                in_data  = 16'h1234 + 16'(cyc);
            end
            rdy = in_ready;
            if (m_state == 2)              begin sig_valid = 1; sig_value = rep; end
            else if (early && m_state == 1) begin sig_valid = 1; sig_value = rep ^ 16'h0001; end
            else                            sig_valid = 0;
            @(posedge clk);
            if (in_valid && rdy) idx++;
            #3;
            cyc++;
        end
        start = 0; in_valid = 0; sig_valid = 0;
        chk(done && pass == exp_pass && fail == !exp_pass, tag, {done, pass, fail}, {1'b1, exp_pass, !exp_pass});
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        chk(0, "watchdog R7", 0, 1);
        summary();
    end

    initial begin
        logic [SW-1:0] e;
        repeat (3) @(posedge clk);
        #3;
        chk(!busy && !done && !pass && !fail && !in_ready, "R8 reset state",
            {busy, done, pass, fail, in_ready}, 0);
        rst_n = 1;

        // R1: zero length uses the seed; R1 wrap of address 0x0001
        run_op(1, 16'h1234, 0, 0, 0, 0, 16'h1232, 1, "R1 zero-length seed");
        run_op(0, 16'h0001, 0, 0, 0, 0, 16'hFFFF, 1, "R1 seed wrap");
        run_op(0, 16'h0001, 0, 0, 0, 0, 16'hFFFE, 0, "R1 seed mismatch R6");

        // R3 branch with erase word: 0x3100 -> 0x6200 ^ 0xFFFF
        run_op(1, 16'h3102, 1, 0, 0, 0, 16'h9DFF, 1, "R3 R5 hand value");

        // R2 branch with zero data word: 0x8000 -> 0x100B
        wq = {16'h0000};
        run_op(0, 16'h8002, 1, 0, 0, 0, 16'h100B, 1, "R2 R4 hand value");

        // R4 stream with gaps, R9 early strobe ignored
        wq = {};
        for (int k = 0; k < 8; k++) wq.push_back(16'hA5C3 ^ 16'(k * 16'h1357));
        e = ref_sig(0, 16'hF00E, 8);
        run_op(0, 16'hF00E, 8, 1, 1, 0, e, 1, "R4 R9 gapped stream");

        // R6 one bit off
        run_op(0, 16'hF00E, 8, 0, 0, 0, e ^ 16'h4000, 0, "R6 single-bit mismatch");

        // R7 start while busy ignored; R5 stream ignored in erase mode
        e = ref_sig(1, 16'h2000, 20);
        run_op(1, 16'h2000, 20, 0, 0, 1, e, 1, "R7 busy start ignored R5");

        // R7 hold with late strobes
        for (int k = 0; k < 5; k++) begin
            @(posedge clk); #3;
            sig_valid = 1; sig_value = ~e;
        end
        @(posedge clk); #3;
        sig_valid = 0;
        chk(done && pass && !fail, "R7 R9 result held", {done, pass, fail}, 3'b110);

        // R5 full-range count
        e = ref_sig(1, 16'h0000, 1023);
        run_op(1, 16'h0000, 1023, 0, 0, 0, e, 1, "R5 full count");

        // R4 long data run with restart from done
        wq = {};
        for (int k = 0; k < 40; k++) wq.push_back(16'((k * 16'h9E37) ^ 16'h8001));
        e = ref_sig(0, 16'h7FFE, 40);
        run_op(0, 16'h7FFE, 40, 1, 0, 0, e, 1, "R4 R2 R3 long stream");

        repeat (3) @(posedge clk);
        summary();
    end
endmodule